// File: doc/BRIEF.md
# Speculative Reorder Buffer with Mispredict Flush

This block keeps the in-flight instructions of a dynamically scheduled pipeline in program order. Each accepted dispatch takes the next slot of a circular array, and the slot index goes back to the dispatcher as the instruction's tag. When a result appears on the common data bus with that tag, the value is stored in the slot and the slot is marked finished. The oldest slot leaves the buffer once it is finished. Its destination register and value are then presented on the register-file write port for that single cycle. No result reaches the architectural registers at any other time.

A branch occupies a slot like any other instruction. When the branch resolves, the resolve port marks its slot finished. If the branch turned out to be mispredicted, every slot dispatched after it is discarded in the same cycle, and a restart pulse tells the front end to refetch. The dispatch tag then resumes at the slot just past the branch. The branch itself stays in the buffer and retires in order. Discarded work never changed architectural state, so dropping it is always safe.

Top module: `rob_spec`

## Requirements
- R1: After reset the occupancy is 0, `full` is 0, `ret_valid` is 0 and `disp_tag` is 0.
- R2: A dispatch is accepted when `disp_valid` and `disp_ready` are both high at a clock edge. It receives tag `disp_tag`, which is the slot index. Tags advance by one modulo 8 per accepted dispatch, and the occupancy rises by one on the next cycle.
- R3: A broadcast whose tag names a held slot stores `cdb_value` in that slot and marks it finished. The value appears on `ret_value` only when that slot retires.
- R4: `ret_valid` is high only when the oldest held slot is finished. A finished younger slot waits behind an unfinished older one. At most one slot retires per cycle. `ret_dest` and `ret_value` carry the retiring slot's dispatch destination and stored value, in dispatch order.
- R5: With 8 slots held, `full` is 1 and `disp_ready` is 0, and a dispatch attempt changes nothing. A slot retiring in a cycle still counts as held in that cycle, so no dispatch is accepted in that cycle.
- R6: A resolve with `br_mispred`=1 on a held slot raises `restart` in that same cycle. All slots younger than the branch are removed and never retire. On the next cycle the occupancy equals the number of slots from the oldest up to and including the branch, and `disp_tag` is the branch tag plus one modulo 8.
- R7: The mispredicted branch's own slot is kept. It retires in order with `ret_value` 0.
- R8: A resolve with `br_mispred`=0 leaves `restart` at 0 and removes nothing. The branch slot retires in order with value 0.
- R9: A broadcast or a resolve whose tag names a slot that is not held is ignored. A later dispatch into that slot starts unfinished, and `restart` stays 0.
- R10: In a cycle where a mispredict is being flushed, `disp_ready` is 0 and no dispatch is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | DEST_W | Destination register of the dispatched instruction |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_tag | output | TAG_W | Tag (slot index) the next dispatch receives |
| full | output | 1 | All slots held |
| occupancy | output | CNT_W | Number of held slots |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag carried by the broadcast |
| cdb_value | input | DATA_W | Result value on the broadcast |
| br_valid | input | 1 | Branch resolve valid |
| br_tag | input | TAG_W | Tag of the resolving branch |
| br_mispred | input | 1 | Resolved branch was mispredicted |
| restart | output | 1 | Mispredict flush taking place this cycle |
| ret_valid | output | 1 | Register-file write this cycle |
| ret_tag | output | TAG_W | Tag of the retiring slot |
| ret_dest | output | DEST_W | Destination register to write |
| ret_value | output | DATA_W | Value to write |

## Verification
The assertions check the following on every cycle:
- a finished flag never exists without a held slot;
- retirement walks the tags one step at a time;
- the occupancy never exceeds the depth and no dispatch lands while full;
- a flush clears exactly the younger slots and moves the dispatch tag to just past the branch;
- a broadcast to an empty slot finishes nothing.

Other properties need the bench's scenarios. These include the order and content of the register-file writes, the occupancy left after a mispredict at each distance from the oldest slot with the ring wrapped to varied start points, the branch's own value-0 retirement, and the refusal of a dispatch while a retire frees a slot in the same cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Distance travelled around the ring going from from_idx to to_idx.
  function automatic int unsigned ring_dist(input int unsigned from_idx,
                                            input int unsigned to_idx,
                                            input int unsigned depth);
    return (to_idx + depth - from_idx) % depth;
  endfunction

  // Slot that follows idx in the ring.
  function automatic int unsigned next_slot(input int unsigned idx,
                                            input int unsigned depth);
    return (idx + 1) % depth;
  endfunction

  // True when slot was allocated after branch, with oldest as the ring origin.
  function automatic logic is_younger(input int unsigned slot,
                                      input int unsigned branch,
                                      input int unsigned oldest,
                                      input int unsigned depth);
    return ring_dist(oldest, slot, depth) > ring_dist(oldest, branch, depth);
  endfunction

endpackage

// File: rtl/rob_slot.sv
module rob_slot #(
  parameter int DEST_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              cdb_hit,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              br_done,
  input  logic              kill,
  input  logic              retire,
  output logic              valid,
  output logic              done,
  output logic [DEST_W-1:0] dest,
  output logic [DATA_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      done  <= 1'b0;
      dest  <= '0;
      value <= '0;
    end else if (alloc) begin
      valid <= 1'b1;
      done  <= 1'b0;
      dest  <= alloc_dest;
      value <= '0;
    end else if (kill || retire) begin
      valid <= 1'b0;
      done  <= 1'b0;
    end else if (valid) begin
      if (cdb_hit) begin
        done  <= 1'b1;
        value <= cdb_value;
      end
      if (br_done) done <= 1'b1;
    end
  end

  // R3: a finished flag only ever sits on a held slot
  a_r3_done_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> valid);

  // R6: a killed slot is empty on the following cycle
  a_r6_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !valid);

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush,
  input  logic [TAG_W-1:0] flush_tag,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  import rob_pkg::*;

  logic [TAG_W-1:0] head_next;
  logic [TAG_W-1:0] tail_next;
  logic [TAG_W-1:0] flush_tail;
  logic [CNT_W-1:0] keep_cnt;

  assign head_next  = TAG_W'(next_slot(32'(head), DEPTH));
  assign tail_next  = TAG_W'(next_slot(32'(tail), DEPTH));
  assign flush_tail = TAG_W'(next_slot(32'(flush_tag), DEPTH));
  assign keep_cnt   = CNT_W'(ring_dist(32'(head), 32'(flush_tag), DEPTH) + 1);
  assign full       = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (retire_fire) head <= head_next;
      if (flush) begin
        tail  <= flush_tail;
        count <= keep_cnt - CNT_W'(retire_fire);
      end else begin
        if (alloc_fire) tail <= tail_next;
        count <= count + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
      end
    end
  end

  // R5: occupancy never exceeds the slot count
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R5: nothing is allocated while every slot is held
  a_r5_no_alloc_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_fire);

  // R2: a lone dispatch raises the occupancy by one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !retire_fire && !flush) |=> count == $past(count) + CNT_W'(1));

endmodule

// File: rtl/rob_spec.sv
module rob_spec #(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 5,
  parameter int DATA_W = 32,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [DEST_W-1:0] disp_dest,
  output logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  output logic              full,
  output logic [CNT_W-1:0]  occupancy,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              br_valid,
  input  logic [TAG_W-1:0]  br_tag,
  input  logic              br_mispred,
  output logic              restart,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [DEST_W-1:0] ret_dest,
  output logic [DATA_W-1:0] ret_value
);
  import rob_pkg::*;

  logic [TAG_W-1:0]  head;
  logic [TAG_W-1:0]  tail;
  logic [DEPTH-1:0]  valid_vec;
  logic [DEPTH-1:0]  done_vec;
  logic [DEPTH-1:0]  alloc_vec;
  logic [DEPTH-1:0]  cdb_hit_vec;
  logic [DEPTH-1:0]  br_done_vec;
  logic [DEPTH-1:0]  kill_vec;
  logic [DEPTH-1:0]  retire_vec;
  logic [DEST_W-1:0] dest_arr  [DEPTH];
  logic [DATA_W-1:0] value_arr [DEPTH];

  // Named internal events
  logic flush;
  logic alloc_fire;
  logic retire_fire;

  assign flush       = br_valid && br_mispred && valid_vec[br_tag];
  assign disp_ready  = !full && !flush;
  assign alloc_fire  = disp_valid && disp_ready;
  assign retire_fire = valid_vec[head] && done_vec[head];

  assign disp_tag  = tail;
  assign restart   = flush;
  assign ret_valid = retire_fire;
  assign ret_tag   = head;
  assign ret_dest  = dest_arr[head];
  assign ret_value = value_arr[head];

  rob_ctrl #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .retire_fire (retire_fire),
    .flush       (flush),
    .flush_tag   (br_tag),
    .head        (head),
    .tail        (tail),
    .count       (occupancy),
    .full        (full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign alloc_vec[i]   = alloc_fire && (tail == TAG_W'(i));
    assign cdb_hit_vec[i] = cdb_valid && (cdb_tag == TAG_W'(i));
    assign br_done_vec[i] = br_valid && (br_tag == TAG_W'(i));
    assign retire_vec[i]  = retire_fire && (head == TAG_W'(i));
    assign kill_vec[i]    = flush && valid_vec[i] &&
                            is_younger(32'(i), 32'(br_tag), 32'(head), DEPTH);

    rob_slot #(
      .DEST_W (DEST_W),
      .DATA_W (DATA_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (alloc_vec[i]),
      .alloc_dest (disp_dest),
      .cdb_hit    (cdb_hit_vec[i]),
      .cdb_value  (cdb_value),
      .br_done    (br_done_vec[i]),
      .kill       (kill_vec[i]),
      .retire     (retire_vec[i]),
      .valid      (valid_vec[i]),
      .done       (done_vec[i]),
      .dest       (dest_arr[i]),
      .value      (value_arr[i])
    );
  end

  // R4: never more than one slot leaves per cycle
  a_r4_one_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(retire_vec));

  // R4: retirement proceeds through consecutive tags
  a_r4_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> ret_tag == TAG_W'(next_slot(32'($past(ret_tag)), DEPTH)));

  // R6: every slot chosen for removal is gone next cycle
  a_r6_killed_gone: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec & $past(kill_vec)) == '0);

  // R6: dispatch resumes just past the mispredicted branch
  a_r6_tail_after_branch: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> disp_tag == TAG_W'(next_slot(32'($past(br_tag)), DEPTH)));

  // R10: nothing is allocated while a flush is under way
  a_r10_no_alloc_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> alloc_vec == '0);

  // R9: a broadcast to an empty slot finishes nothing
  a_r9_stray_cdb: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && !valid_vec[cdb_tag] && !br_valid) |=>
      (done_vec & ~$past(done_vec)) == '0);

endmodule

// File: tb/rob_spec_tb.sv
module rob_spec_tb;
  localparam int DEPTH  = 8;
  localparam int DEST_W = 5;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 3;
  localparam int CNT_W  = 4;

  logic              clk;
  logic              rst_n;
  logic              disp_valid;
  logic [DEST_W-1:0] disp_dest;
  logic              disp_ready;
  logic [TAG_W-1:0]  disp_tag;
  logic              full;
  logic [CNT_W-1:0]  occupancy;
  logic              cdb_valid;
  logic [TAG_W-1:0]  cdb_tag;
  logic [DATA_W-1:0] cdb_value;
  logic              br_valid;
  logic [TAG_W-1:0]  br_tag;
  logic              br_mispred;
  logic              restart;
  logic              ret_valid;
  logic [TAG_W-1:0]  ret_tag;
  logic [DEST_W-1:0] ret_dest;
  logic [DATA_W-1:0] ret_value;

  rob_spec #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_ready(disp_ready),
    .disp_tag(disp_tag), .full(full), .occupancy(occupancy),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .br_valid(br_valid), .br_tag(br_tag), .br_mispred(br_mispred),
    .restart(restart), .ret_valid(ret_valid), .ret_tag(ret_tag),
    .ret_dest(ret_dest), .ret_value(ret_value)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int q_dest[$];
  int q_val[$];
  bit done_flag = 0;

  task automatic chk_eq(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Samples the retire port mid-cycle, then moves to the next falling edge.
  task automatic cyc();
    #2;
    if (ret_valid) begin
      if (q_dest.size() == 0) begin
        chk_eq("R6 removed entry retired (tag)", ret_tag, -1);
      end else begin
        chk_eq("R4 retire dest order", ret_dest, q_dest.pop_front());
        chk_eq("R3 retire value", ret_value, q_val.pop_front());
      end
    end
    @(negedge clk);
  endtask

  task automatic do_disp(input int dest);
    disp_valid = 1'b1;
    disp_dest  = DEST_W'(dest);
    cyc();
    disp_valid = 1'b0;
  endtask

  task automatic send_cdb(input int tag, input int val);
    cdb_valid = 1'b1;
    cdb_tag   = TAG_W'(tag);
    cdb_value = DATA_W'(val);
    cyc();
    cdb_valid = 1'b0;
  endtask

  task automatic drain(input int limit);
    for (int w = 0; w < limit && occupancy != 0; w++) cyc();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    int steps;
    rst_n = 1'b0; disp_valid = 1'b0; disp_dest = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0;
    br_valid = 1'b0; br_tag = '0; br_mispred = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk_eq("R1 occupancy", occupancy, 0);
    chk_eq("R1 full", full, 0);
    chk_eq("R1 ret_valid", ret_valid, 0);
    chk_eq("R1 disp_tag", disp_tag, 0);

    // R2 fill all slots
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      chk_eq("R2 tag is slot index", disp_tag, i);
      chk_eq("R2 ready while not full", disp_ready, 1);
      do_disp(i + 1);
      chk_eq("R2 occupancy step", occupancy, i + 1);
    end
    chk_eq("R5 full", full, 1);
    chk_eq("R5 ready low when full", disp_ready, 0);
    do_disp(30);
    chk_eq("R5 dispatch ignored when full", occupancy, DEPTH);

    // R3/R4 out-of-order completion, youngest first
    for (int t = DEPTH - 1; t >= 1; t--) send_cdb(t, 100 + t);
    cyc();
    chk_eq("R4 younger finished wait for oldest", ret_valid, 0);
    for (int i = 0; i < DEPTH; i++) begin
      q_dest.push_back(i + 1);
      q_val.push_back(100 + i);
    end
    send_cdb(0, 100);
    #1;
    chk_eq("R4 oldest finished retires", ret_valid, 1);
    chk_eq("R5 full during retire", full, 1);
    chk_eq("R5 no same-cycle reuse", disp_ready, 0);
    disp_valid = 1'b1;
    disp_dest  = 5'd29;
    cyc();
    disp_valid = 1'b0;
    chk_eq("R5 retire without dispatch", occupancy, DEPTH - 1);
    steps = 0;
    for (int w = 0; w < 20 && occupancy != 0; w++) begin
      cyc();
      steps++;
    end
    chk_eq("R4 one retire per cycle", steps, DEPTH - 1);
    chk_eq("R4 all entries retired", q_dest.size(), 0);

    // R8 correctly predicted branch (tag 0) plus one follower (tag 1)
    do_disp(9);
    do_disp(10);
    br_valid = 1'b1; br_tag = 3'd0; br_mispred = 1'b0;
    #1;
    chk_eq("R8 no restart on correct branch", restart, 0);
    cyc();
    br_valid = 1'b0;
    chk_eq("R8 nothing removed", occupancy, 2);
    q_dest.push_back(9);  q_val.push_back(0);
    q_dest.push_back(10); q_val.push_back(55);
    send_cdb(1, 55);
    drain(10);
    chk_eq("R8 both retired", q_dest.size(), 0);

    // R9 stray broadcast and resolve on empty slot 2
    chk_eq("R9 empty before stray", occupancy, 0);
    cdb_valid = 1'b1; cdb_tag = 3'd2; cdb_value = 32'd77;
    br_valid = 1'b1; br_tag = 3'd2; br_mispred = 1'b1;
    #1;
    chk_eq("R9 resolve on empty slot ignored", restart, 0);
    cyc();
    cdb_valid = 1'b0; br_valid = 1'b0; br_mispred = 1'b0;
    #1;
    chk_eq("R9 dispatch lands in slot 2", disp_tag, 2);
    do_disp(11);
    for (int w = 0; w < 3; w++) begin
      cyc();
      chk_eq("R9 new entry starts unfinished", ret_valid, 0);
    end
    q_dest.push_back(11); q_val.push_back(12);
    send_cdb(2, 12);
    drain(10);
    chk_eq("R9 entry retired after real result", q_dest.size(), 0);

    // R6/R7/R10 mispredict at every distance from the oldest entry
    base = 3;
    for (int p = 0; p < DEPTH - 1; p++) begin
      chk_eq("R6 sweep start tag", disp_tag, base);
      for (int k = 0; k < DEPTH - 1; k++) do_disp((k == p) ? 20 + p : k + 1);
      for (int k = p + 1; k < DEPTH - 1; k++) send_cdb((base + k) % DEPTH, 200 + k);
      br_valid = 1'b1; br_tag = TAG_W'((base + p) % DEPTH); br_mispred = 1'b1;
      disp_valid = 1'b1; disp_dest = 5'd31;
      #1;
      chk_eq("R6 restart on mispredict", restart, 1);
      chk_eq("R10 dispatch blocked during flush", disp_ready, 0);
      cyc();
      br_valid = 1'b0; br_mispred = 1'b0; disp_valid = 1'b0;
      chk_eq("R6 occupancy up to branch", occupancy, p + 1);
      chk_eq("R6 tag after branch", disp_tag, (base + p + 1) % DEPTH);
      for (int k = 0; k < p; k++) begin
        q_dest.push_back(k + 1);
        q_val.push_back(300 + k);
      end
      q_dest.push_back(20 + p);
      q_val.push_back(0);
      for (int k = 0; k < p; k++) send_cdb((base + k) % DEPTH, 300 + k);
      drain(12);
      chk_eq("R7 branch and elders retired", q_dest.size(), 0);
      chk_eq("R6 buffer empty after drain", occupancy, 0);
      base = (base + p + 1) % DEPTH;
    end

    done_flag = 1;
    summary();
    $finish;
  end
endmodule